// File: doc/BRIEF.md
# Endian-Aware Module Window Decoder

This block sits between a host access port and four plug-in module slots on a carrier. It accepts one host access at a time on a valid/ready handshake. Each access names one of four windows: the configuration bytes, a combined I/O / ID / interrupt window, a 16-bit memory window and an 8-bit memory window. The block turns that access into a single module cycle: a slot number, a space code, an offset, a write strobe and data. When the module responds, the block returns the read data to the host. Accesses to a slot with no module installed never reach the module. Reads of them return zero and writes are dropped.

Three windows can be switched to big-endian mode. These are the register window, whose flag is only exported, the I/O / ID / interrupt window and the 16-bit memory window. Each flag lives in bit 0 of a configuration byte. In big-endian mode a byte access flips address bit 0, and a 16-bit access swaps the two data bytes on both the write path and the read path. The 8-bit memory window is never adjusted.

Reads of interrupt-space offsets 0 and 2 act as acknowledges. Such a read pulses an acknowledge line for that slot's interrupt 0 or 1. The pulse only happens when the matching status bit is set and the line is configured as level-sensitive.

Top module: `modwin_decoder`

## Requirements
- R1: Window code 1 (I/O / ID / interrupt, 1 KiB) is decoded as follows. The slot is addr[9:8]. Address bits [7:6] equal to 2 give space ID (mod_space 1), bits equal to 3 give space INT (mod_space 2), and any other value gives space I/O (mod_space 0). The offset is addr[6:0] for I/O and addr[5:0] for ID and INT.
- R2: Window code 2 (16-bit memory, 32 MiB) is decoded with slot addr[24:23], offset addr[22:0] and mod_space 3.
- R3: Window code 3 (8-bit memory, 16 MiB) is decoded with slot addr[23:22], offset addr[21:0] and mod_space 4. Neither the address nor the data is ever endian-adjusted in this window.
- R4: When window 1 or 2 is in big-endian mode, a byte access (req_size16 = 0) reaches the module with address bit 0 inverted.
- R5: When window 1 or 2 is in big-endian mode, a 16-bit access has its write data bytes swapped toward the module and its read data bytes swapped toward the host. A byte read returns the module's low byte zero-extended.
- R6: Window code 0 addresses configuration bytes through addr[7:0]. Writes to bytes 0x2B, 0x2F and 0x33 set the big-endian flag of the register window, window 1 and window 2 from data bit 0. A read of one of those bytes returns its stored value (0xD4, 0x14 and 0x14) ORed with the flag. Every other configuration byte reads 0 and ignores writes. be_regwin shows the register-window flag.
- R7: An access whose slot has slot_present low produces no module cycle. It completes with rsp_rdata 0, and a write to it is dropped.
- R8: A read in INT space at offset 0 or 2 of a present slot pulses irq_ack bit slot*2+line for one cycle, where line is 0 for offset 0 and 1 for offset 2. The pulse happens only when irq_status of that bit is 1 and irq_edge of that bit is 0. Every other access leaves irq_ack at 0.
- R9: req_ready is high only when the block is idle. After an access is accepted, rsp_valid is high for exactly one cycle. That cycle is the one after the module's mod_ack, or the one after acceptance when no module cycle takes place.
- R10: After reset, req_ready is 1, mod_valid and rsp_valid are 0, irq_ack is 0 and all three big-endian flags are 0.
- R11: While mod_valid is high and mod_ack is low, mod_valid, mod_slot, mod_offset and mod_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_win | input | 2 | Window: 0 config, 1 I/O-ID-INT, 2 mem16, 3 mem8 |
| req_addr | input | 25 | Byte address within the window |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Access complete, one cycle |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| slot_present | input | 4 | One bit per slot, 1 = module installed |
| mod_valid | output | 1 | Module cycle in progress |
| mod_write | output | 1 | Module cycle is a write |
| mod_size16 | output | 1 | Module cycle is 16 bits wide |
| mod_slot | output | 2 | Target slot |
| mod_space | output | 3 | 0 I/O, 1 ID, 2 INT, 3 mem16, 4 mem8 |
| mod_offset | output | 23 | Offset within the space |
| mod_wdata | output | 16 | Write data toward the module |
| mod_ack | input | 1 | Module completes the cycle |
| mod_rdata | input | 16 | Module read data, valid with mod_ack |
| irq_status | input | 8 | Interrupt status, bit slot*2+line |
| irq_edge | input | 8 | 1 = line edge-configured, bit slot*2+line |
| irq_ack | output | 8 | One-cycle acknowledge pulse per line |
| be_regwin | output | 1 | Big-endian flag of the register window |

## Verification
A corrupted big-endian flag shows up on the very next access to its window. In that access a byte offset has the wrong low bit, or 16-bit data arrives with its bytes swapped, at the cycle mod_valid rises. A configuration read exposes the flag one cycle after acceptance. A stuck state register shows as req_ready staying low, or rsp_valid lasting more than one cycle, within two cycles of mod_ack. A wrong slot-present or edge decision shows at acceptance, as a module cycle that should not exist or as an irq_ack pulse in the cycle after the request.

// File: rtl/mwd_pkg.sv
// Shared types for the module window decoder.
// Assumes a four-slot carrier with 16-bit host data.
package mwd_pkg;

    typedef enum logic [1:0] {
        WIN_CFG     = 2'd0,
        WIN_IOIDINT = 2'd1,
        WIN_MEM16   = 2'd2,
        WIN_MEM8    = 2'd3
    } win_t;

    typedef enum logic [2:0] {
        SP_IO    = 3'd0,
        SP_ID    = 3'd1,
        SP_INT   = 3'd2,
        SP_MEM16 = 3'd3,
        SP_MEM8  = 3'd4
    } space_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOD  = 2'd1,
        ST_RESP = 2'd2
    } state_t;

endpackage

// File: rtl/mwd_lane_swap.sv
// Byte-lane reverser for one data word.
// When swap is high the bytes come out in reverse order; otherwise pass through.
// Assumes DATA_W is a whole number of bytes.
module mwd_lane_swap #(
    parameter int DATA_W = 16
) (
    input  logic              swap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] reversed;

    // Build the byte-reversed word lane by lane.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign reversed[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end

    // Select reversed or straight data.
    always_comb dout = swap ? reversed : din;
endmodule

// File: rtl/mwd_addr_decode.sv
// Splits an (already endian-adjusted) window address into slot, space and offset.
// Also flags interrupt-space offsets 0 and 2, which act as acknowledges.
// Assumes the window layout fixed by the carrier: slot field at bits 9:8 of
// the I/O-ID-INT window and at the top of each memory window.
module mwd_addr_decode
    import mwd_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int SLOT_W = 2,
    localparam int OFF_W = ADDR_W - SLOT_W
) (
    input  win_t              win,
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output space_t            space,
    output logic [OFF_W-1:0]  offset,
    output logic              ack_hit,
    output logic              ack_line
);
    localparam int IO_SPC_LSB  = 6;
    localparam int IO_SLOT_LSB = 8;
    localparam int IO_OFF_W    = 7;
    localparam int IDI_OFF_W   = 6;
    localparam int M16_OFF_W   = ADDR_W - SLOT_W;
    localparam int M8_OFF_W    = ADDR_W - 1 - SLOT_W;

    // Field extraction per window.
    always_comb begin
        slot   = '0;
        space  = SP_IO;
        offset = '0;
        case (win)
            WIN_IOIDINT: begin
                slot = addr[IO_SLOT_LSB +: SLOT_W];
                case (addr[IO_SPC_LSB +: 2])
                    2'd2: begin
                        space  = SP_ID;
                        offset = OFF_W'(addr[IDI_OFF_W-1:0]);
                    end
                    2'd3: begin
                        space  = SP_INT;
                        offset = OFF_W'(addr[IDI_OFF_W-1:0]);
                    end
                    default: begin
                        space  = SP_IO;
                        offset = OFF_W'(addr[IO_OFF_W-1:0]);
                    end
                endcase
            end
            WIN_MEM16: begin
                slot   = addr[M16_OFF_W +: SLOT_W];
                space  = SP_MEM16;
                offset = addr[M16_OFF_W-1:0];
            end
            WIN_MEM8: begin
                slot   = addr[M8_OFF_W +: SLOT_W];
                space  = SP_MEM8;
                offset = OFF_W'(addr[M8_OFF_W-1:0]);
            end
            default: ;
        endcase
    end

    // Acknowledge offsets: 0 selects line 0, 2 selects line 1.
    always_comb begin
        ack_hit  = (win == WIN_IOIDINT) && (space == SP_INT) &&
                   (offset[IDI_OFF_W-1:2] == '0) && !offset[0];
        ack_line = offset[1];
    end
endmodule

// File: rtl/mwd_cfg_flags.sv
// Configuration bytes that carry the big-endian flags, one byte per window.
// Flag i lives in bit 0 of byte BASE + i*STRIDE; reads return PRESETS | flag.
// All other configuration bytes read as zero here.
module mwd_cfg_flags #(
    parameter int              N_FLAGS = 3,
    parameter int              CFG_AW  = 8,
    parameter int              BASE    = 'h2B,
    parameter int              STRIDE  = 4,
    parameter logic [8*N_FLAGS-1:0] PRESETS = {8'h14, 8'h14, 8'hD4}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CFG_AW-1:0]  addr,
    input  logic [7:0]         wbyte,
    output logic [N_FLAGS-1:0] flags,
    output logic [7:0]         rbyte
);
    logic [N_FLAGS-1:0] hit;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        // Address match for this flag byte.
        assign hit[i] = (addr == CFG_AW'(BASE + i*STRIDE));

        // Flag register: cleared by reset, loaded from bit 0 on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                flags[i] <= 1'b0;
            else if (wr_en && hit[i])  flags[i] <= wbyte[0];
        end
    end

    // Read mux: preset byte with the flag ORed into bit 0.
    always_comb begin
        rbyte = 8'h00;
        for (int i = 0; i < N_FLAGS; i++) begin
            if (hit[i]) rbyte = PRESETS[8*i +: 8] | {7'b0, flags[i]};
        end
    end
endmodule

// File: rtl/modwin_decoder.sv
// Top of the module window decoder. Accepts one host access at a time,
// applies the window's endian mode, decodes slot/space/offset, runs one
// module cycle (or none for config and empty slots) and returns a response
// the cycle after completion. Assumes the module side holds mod_rdata valid
// in the mod_ack cycle and that req_* is stable while req_valid is high.
module modwin_decoder
    import mwd_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int SLOT_W = 2,
    parameter int DATA_W = 16,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int IRQ_W     = 2 * NUM_SLOTS,
    localparam int OFF_W     = ADDR_W - SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [1:0]        req_win,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [NUM_SLOTS-1:0] slot_present,
    output logic              mod_valid,
    output logic              mod_write,
    output logic              mod_size16,
    output logic [SLOT_W-1:0] mod_slot,
    output logic [2:0]        mod_space,
    output logic [OFF_W-1:0]  mod_offset,
    output logic [DATA_W-1:0] mod_wdata,
    input  logic              mod_ack,
    input  logic [DATA_W-1:0] mod_rdata,
    input  logic [IRQ_W-1:0]  irq_status,
    input  logic [IRQ_W-1:0]  irq_edge,
    output logic [IRQ_W-1:0]  irq_ack,
    output logic              be_regwin
);
    localparam int N_FLAGS = 3;

    state_t            state_q;
    win_t              win;
    logic [N_FLAGS-1:0] be_flags;
    logic              be_sel;
    logic              accept;
    logic [ADDR_W-1:0] adj_addr;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rdata_sw;
    logic [7:0]        cfg_rbyte;
    logic [SLOT_W-1:0] dec_slot;
    space_t            dec_space;
    logic [OFF_W-1:0]  dec_off;
    logic              dec_ack_hit;
    logic              dec_ack_line;
    logic              rd_swap_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [SLOT_W:0]   ack_idx;

    // Request qualification and window type.
    always_comb begin
        win    = win_t'(req_win);
        accept = req_valid && (state_q == ST_IDLE);
    end

    // Endian mode of the addressed window; memory-8 and config are never adjusted.
    always_comb begin
        case (win)
            WIN_IOIDINT: be_sel = be_flags[1];
            WIN_MEM16:   be_sel = be_flags[2];
            default:     be_sel = 1'b0;
        endcase
    end

    // Byte accesses in big-endian mode flip address bit 0.
    always_comb adj_addr = req_addr ^ ADDR_W'(be_sel && !req_size16);

    always_comb ack_idx = {dec_slot, dec_ack_line};

    mwd_cfg_flags #(
        .N_FLAGS (N_FLAGS),
        .CFG_AW  (8)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept && req_write && (win == WIN_CFG)),
        .addr  (req_addr[7:0]),
        .wbyte (req_wdata[7:0]),
        .flags (be_flags),
        .rbyte (cfg_rbyte)
    );

    mwd_addr_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) u_dec (
        .win      (win),
        .addr     (adj_addr),
        .slot     (dec_slot),
        .space    (dec_space),
        .offset   (dec_off),
        .ack_hit  (dec_ack_hit),
        .ack_line (dec_ack_line)
    );

    mwd_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .swap (be_sel && req_size16),
        .din  (req_wdata),
        .dout (wdata_sw)
    );

    mwd_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .swap (rd_swap_q),
        .din  (mod_rdata),
        .dout (rdata_sw)
    );

    // Access sequencer: idle -> module cycle or direct response -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mod_write  <= 1'b0;
            mod_size16 <= 1'b0;
            mod_slot   <= '0;
            mod_space  <= SP_IO;
            mod_offset <= '0;
            mod_wdata  <= '0;
            rd_swap_q  <= 1'b0;
            rsp_data_q <= '0;
            irq_ack    <= '0;
        end else begin
            irq_ack <= '0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    if (win == WIN_CFG) begin
                        rsp_data_q <= req_write ? '0 : DATA_W'(cfg_rbyte);
                        state_q    <= ST_RESP;
                    end else if (!slot_present[dec_slot]) begin
                        rsp_data_q <= '0;
                        state_q    <= ST_RESP;
                    end else begin
                        mod_write  <= req_write;
                        mod_size16 <= req_size16;
                        mod_slot   <= dec_slot;
                        mod_space  <= dec_space;
                        mod_offset <= dec_off;
                        mod_wdata  <= wdata_sw;
                        rd_swap_q  <= be_sel && req_size16;
                        if (!req_write && dec_ack_hit &&
                            irq_status[ack_idx] && !irq_edge[ack_idx])
                            irq_ack[ack_idx] <= 1'b1;
                        state_q    <= ST_MOD;
                    end
                end
                ST_MOD: if (mod_ack) begin
                    if (mod_write)       rsp_data_q <= '0;
                    else if (mod_size16) rsp_data_q <= rdata_sw;
                    else                 rsp_data_q <= DATA_W'(mod_rdata[7:0]);
                    state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mod_valid = (state_q == ST_MOD);
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rsp_data_q;
        be_regwin = be_flags[0];
    end
endmodule

// File: rtl/mwd_checker.sv
// Protocol checker for modwin_decoder, attached by bind below.
module mwd_checker #(
    parameter int SLOT_W = 2,
    parameter int OFF_W  = 23,
    parameter int DATA_W = 16,
    localparam int NUM_SLOTS = 1 << SLOT_W,
    localparam int IRQ_W     = 2 * NUM_SLOTS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic                 mod_valid,
    input logic                 mod_ack,
    input logic [SLOT_W-1:0]    mod_slot,
    input logic [OFF_W-1:0]     mod_offset,
    input logic [DATA_W-1:0]    mod_wdata,
    input logic [NUM_SLOTS-1:0] slot_present,
    input logic [IRQ_W-1:0]     irq_ack,
    input logic [IRQ_W-1:0]     irq_edge
);
    // R10: reset leaves the block with no cycle in flight.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!mod_valid && !rsp_valid && req_ready && irq_ack == '0));

    // R9: an accepted request makes the block busy.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: the response lasts one cycle.
    a_r9_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: response follows the module acknowledge by one cycle.
    a_r9_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_valid && mod_ack) |=> rsp_valid);

    // R11: module request held until acknowledged.
    a_r11_mod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_valid && !mod_ack) |=> (mod_valid && $stable(mod_slot) &&
                                     $stable(mod_offset) && $stable(mod_wdata)));

    // R7: no module cycle toward an empty slot.
    a_r7_present_only: assert property (@(posedge clk) disable iff (!rst_n)
        mod_valid |-> slot_present[mod_slot]);

    // R8: at most one acknowledge line at a time, never an edge-configured one.
    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));
    a_r8_ack_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |-> ((irq_ack & $past(irq_edge)) == '0));
endmodule

bind modwin_decoder mwd_checker #(
    .SLOT_W (SLOT_W),
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) u_mwd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .mod_valid    (mod_valid),
    .mod_ack      (mod_ack),
    .mod_slot     (mod_slot),
    .mod_offset   (mod_offset),
    .mod_wdata    (mod_wdata),
    .slot_present (slot_present),
    .irq_ack      (irq_ack),
    .irq_edge     (irq_edge)
);

// File: tb/modwin_decoder_test.sv
// Directed bench for modwin_decoder: one task per scenario.
module modwin_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_size16 = 1'b0;
    logic [1:0]  req_win = 2'd0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [3:0]  slot_present = 4'hF;
    logic        mod_valid, mod_write, mod_size16;
    logic [1:0]  mod_slot;
    logic [2:0]  mod_space;
    logic [22:0] mod_offset;
    logic [15:0] mod_wdata;
    logic        mod_ack = 1'b0;
    logic [15:0] mod_rdata = '0;
    logic [7:0]  irq_status = '0;
    logic [7:0]  irq_edge = '0;
    logic [7:0]  irq_ack;
    logic        be_regwin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Values captured by run_access.
    bit          g_mod;
    logic [1:0]  g_slot;
    logic [2:0]  g_space;
    logic [22:0] g_off;
    logic [15:0] g_mwdata;
    logic        g_mwrite;
    logic [15:0] g_rdata;
    logic [7:0]  g_ack;

    modwin_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size16(req_size16), .req_win(req_win),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .slot_present(slot_present), .mod_valid(mod_valid),
        .mod_write(mod_write), .mod_size16(mod_size16), .mod_slot(mod_slot),
        .mod_space(mod_space), .mod_offset(mod_offset), .mod_wdata(mod_wdata),
        .mod_ack(mod_ack), .mod_rdata(mod_rdata), .irq_status(irq_status),
        .irq_edge(irq_edge), .irq_ack(irq_ack), .be_regwin(be_regwin)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One complete host access; the module side answers with mrd after one wait cycle.
    task automatic run_access(input logic [1:0] win, input bit wr, input bit sz16,
                              input logic [24:0] addr, input logic [15:0] wd,
                              input logic [15:0] mrd);
        g_mod = 0;
        @(negedge clk);
        req_valid = 1; req_win = win; req_write = wr; req_size16 = sz16;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R9 busy after accept", {31'b0, req_ready}, 0);
        g_ack = irq_ack;
        if (mod_valid) begin
            g_mod = 1; g_slot = mod_slot; g_space = mod_space; g_off = mod_offset;
            g_mwdata = mod_wdata; g_mwrite = mod_write;
            @(negedge clk);
            chk(mod_valid && mod_offset == g_off && mod_wdata == g_mwdata,
                "R11 hold until ack", {9'b0, mod_offset}, {9'b0, g_off});
            mod_ack = 1; mod_rdata = mrd;
            @(negedge clk);
            mod_ack = 0;
        end
        chk(rsp_valid, "R9 response cycle", {31'b0, rsp_valid}, 1);
        g_rdata = rsp_rdata;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9 single response", {30'b0, rsp_valid, req_ready}, 1);
    endtask

    task automatic expect_mod(input string req, input logic [1:0] slot,
                              input logic [2:0] space, input logic [22:0] off);
        chk(g_mod, {req, " module cycle"}, {31'b0, g_mod}, 1);
        chk(g_slot == slot && g_space == space && g_off == off, {req, " slot/space/offset"},
            {4'b0, g_slot, g_space, g_off}, {4'b0, slot, space, off});
    endtask

    task automatic t_reset;
        chk(req_ready && !mod_valid && !rsp_valid && irq_ack == 0 && !be_regwin,
            "R10 reset outputs", {27'b0, req_ready, mod_valid, rsp_valid, |irq_ack, be_regwin},
            32'h10);
        run_access(2'd0, 0, 0, 25'h2B, 0, 0);
        chk(g_rdata == 16'h00D4, "R10 flag clear after reset", {16'b0, g_rdata}, 32'hD4);
    endtask

    task automatic t_ioidint;
        run_access(2'd1, 0, 1, 25'h26A, 0, 16'h1234);
        expect_mod("R1 io", 2'd2, 3'd0, 23'h6A);
        chk(g_rdata == 16'h1234, "R1 io read data", {16'b0, g_rdata}, 32'h1234);
        run_access(2'd1, 0, 0, 25'h195, 0, 16'h0077);
        expect_mod("R1 id", 2'd1, 3'd1, 23'h15);
        run_access(2'd1, 1, 0, 25'h3FF, 16'h00AB, 0);
        expect_mod("R1 int", 2'd3, 3'd2, 23'h3F);
        run_access(2'd1, 0, 0, 25'h07F, 0, 0);
        expect_mod("R1 io code0", 2'd0, 3'd0, 23'h7F);
    endtask

    task automatic t_memwins;
        run_access(2'd2, 1, 1, 25'h1812346, 16'hBEEF, 0);
        expect_mod("R2 mem16", 2'd3, 3'd3, 23'h012346);
        chk(g_mwdata == 16'hBEEF && g_mwrite, "R2 mem16 write data", {16'b0, g_mwdata}, 32'hBEEF);
        run_access(2'd3, 1, 0, 25'h082ABCD, 16'h005A, 0);
        expect_mod("R3 mem8", 2'd2, 3'd4, 23'h02ABCD);
    endtask

    task automatic t_ack;
        irq_status = 8'h0C; irq_edge = 8'h00;
        run_access(2'd1, 0, 1, 25'h1C0, 0, 0);
        chk(g_ack == 8'h04, "R8 ack line0", {24'b0, g_ack}, 32'h04);
        run_access(2'd1, 0, 1, 25'h1C2, 0, 0);
        chk(g_ack == 8'h08, "R8 ack line1", {24'b0, g_ack}, 32'h08);
        run_access(2'd1, 0, 0, 25'h1C1, 0, 0);
        chk(g_ack == 8'h00, "R8 no ack odd offset", {24'b0, g_ack}, 0);
        run_access(2'd1, 1, 1, 25'h1C0, 0, 0);
        chk(g_ack == 8'h00, "R8 no ack on write", {24'b0, g_ack}, 0);
        irq_edge = 8'h04;
        run_access(2'd1, 0, 1, 25'h1C0, 0, 0);
        chk(g_ack == 8'h00, "R8 no ack edge line", {24'b0, g_ack}, 0);
        irq_status = 8'h00; irq_edge = 8'h00;
        run_access(2'd1, 0, 1, 25'h1C2, 0, 0);
        chk(g_ack == 8'h00, "R8 no ack status clear", {24'b0, g_ack}, 0);
    endtask

    task automatic t_cfg;
        run_access(2'd0, 1, 0, 25'h2F, 16'h0001, 0);
        run_access(2'd0, 0, 0, 25'h2F, 0, 0);
        chk(g_rdata == 16'h0015, "R6 io flag readback", {16'b0, g_rdata}, 32'h15);
        run_access(2'd0, 1, 0, 25'h33, 16'h00FF, 0);
        run_access(2'd0, 0, 0, 25'h33, 0, 0);
        chk(g_rdata == 16'h0015, "R6 mem16 flag readback", {16'b0, g_rdata}, 32'h15);
        run_access(2'd0, 1, 0, 25'h2B, 16'h0001, 0);
        chk(be_regwin, "R6 register window flag", {31'b0, be_regwin}, 1);
        run_access(2'd0, 1, 0, 25'h10, 16'h00FF, 0);
        run_access(2'd0, 0, 0, 25'h10, 0, 0);
        chk(g_rdata == 16'h0000, "R6 other byte ignored", {16'b0, g_rdata}, 0);
    endtask

    task automatic t_endian;
        run_access(2'd1, 0, 0, 25'h204, 0, 16'h00C3);
        expect_mod("R4 io byte flip", 2'd2, 3'd0, 23'h05);
        chk(g_rdata == 16'h00C3, "R5 byte read low lane", {16'b0, g_rdata}, 32'hC3);
        run_access(2'd1, 0, 1, 25'h204, 0, 16'hA1B2);
        expect_mod("R5 io word no flip", 2'd2, 3'd0, 23'h04);
        chk(g_rdata == 16'hB2A1, "R5 read swap", {16'b0, g_rdata}, 32'hB2A1);
        run_access(2'd1, 1, 1, 25'h204, 16'h1122, 0);
        chk(g_mwdata == 16'h2211, "R5 write swap", {16'b0, g_mwdata}, 32'h2211);
        run_access(2'd2, 0, 0, 25'h0800010, 0, 16'h55AA);
        expect_mod("R4 mem16 byte flip", 2'd1, 3'd3, 23'h11);
        chk(g_rdata == 16'h00AA, "R4 mem16 byte data", {16'b0, g_rdata}, 32'hAA);
        run_access(2'd3, 0, 0, 25'h0000010, 0, 16'h0044);
        expect_mod("R3 mem8 unadjusted", 2'd0, 3'd4, 23'h10);
    endtask

    task automatic t_empty;
        slot_present = 4'b0111;
        run_access(2'd1, 0, 1, 25'h300, 0, 16'hFFFF);
        chk(!g_mod && g_rdata == 16'h0, "R7 empty read", {15'b0, g_mod, g_rdata}, 0);
        run_access(2'd2, 1, 1, 25'h1800000, 16'h1234, 0);
        chk(!g_mod, "R7 empty write dropped", {31'b0, g_mod}, 0);
        slot_present = 4'hF;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_ioidint;
        t_memwins;
        t_ack;
        t_cfg;
        t_endian;
        t_empty;
        repeat (2) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule